// File: doc/BRIEF.md
# Variable-Modulus DDS Phase Generator

This block is the numeric core of a direct digital synthesizer. A phase accumulator adds a programmable step on every clock. It wraps at a programmable modulus instead of at a power of two. The output frequency is therefore the clock frequency times step divided by modulus, and any rational fraction of the clock can be reached exactly. A modulus of zero gives the plain binary wrap at 2^32.

The phase is reduced to a 14-bit table address, one cycle after the accumulator. In modulus mode this is the phase scaled to the modulus range. In binary mode the top phase bits are used. This shortening from phase to address is where the spurs of a synthesizer come from. A quarter-wave sine stage folds the address into one quadrant and computes a signed sample one cycle after the address. A wrap pulse travels alongside the address.

Step and modulus are captured together on a load strobe. A separate clear pulse restarts the phase at zero.

Top module: `dds_varmod_gen`

## Requirements
- R1: While reset is asserted, `addr_o`, `sample_o` and `wrap_o` are all zero.
- R2: In modulus mode (captured modulus M not zero, captured step S < M), the phase advances by S each clock. When the sum reaches or exceeds M, M is subtracted. The phase always stays below M.
- R3: With captured modulus zero, the phase wraps at 2^32 with no other effect, and `addr_o` is phase bits [31:18].
- R4: `step_i` and `mod_i` are captured only on a clock where `load_i` is high. That clock also clears the phase to zero. Changes on `step_i` and `mod_i` at other times leave the outputs unaffected.
- R5: A high `phase_clr_i` clears the phase at the next clock edge, and no wrap is reported for that edge.
- R6: `wrap_o` is high for exactly those cycles whose `addr_o` is the first address after an accumulator wrap. It is aligned with `addr_o`.
- R7: In modulus mode, `addr_o` is floor(phase * 2^14 / M), registered one clock after the phase.
- R8: `sample_o` is 32767*sin(2*pi*a/16384) for the previous cycle's address a, within 16 LSB. It is exact at the quadrant points: 0 at a=0 and a=8192, +32767 at a=4096, and -32767 at a=12288.
- R9: In binary mode, a step that is a multiple of 2^18 keeps the discarded phase bits at zero. `addr_o` then advances by exactly step/2^18 (mod 2^14) each clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture step and modulus, clear phase |
| step_i | input | 32 | Phase increment per clock |
| mod_i | input | 32 | Wrap modulus; zero selects binary wrap |
| phase_clr_i | input | 1 | Clear the phase at the next edge |
| addr_o | output | 14 | Table address derived from the phase |
| sample_o | output | 16 | Signed sine sample of the previous address |
| wrap_o | output | 1 | Accumulator wrapped, aligned with addr_o |

## Verification
The bench builds the block with its default parameters: a 32-bit accumulator, a 14-bit address and 16-bit samples. These values let a modulus of 16384 with a step of 1 walk every table address in turn, so the whole folded sine is checked against a real-valued reference. Small moduli such as 1000 reach wraps in both the near-zero and the near-every-cycle regimes within a few hundred cycles. Binary steps of 2^30 and 3*2^18 land exactly on the quadrant points and on phase-coherent address sequences.

// File: rtl/dds_pkg.sv
package dds_pkg;
  // Q15 coefficients of sin(pi/2 * x) ~ x*(A - x^2*(B - C*x^2)), x in [0,1]
  localparam logic [31:0] K_A = 32'd51472;
  localparam logic [31:0] K_B = 32'd21090;
  localparam logic [31:0] K_C = 32'd2385;
  localparam int unsigned Q_FRAC = 15;

  // quadrant of the sine wave selected by the two address MSBs
  typedef enum logic [1:0] {
    QD_POS_RISE = 2'd0,
    QD_POS_FALL = 2'd1,
    QD_NEG_RISE = 2'd2,
    QD_NEG_FALL = 2'd3
  } quad_e;
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             clr_i,
  input  logic [ACC_W-1:0] step_i,
  input  logic [ACC_W-1:0] mod_i,
  output logic [ACC_W-1:0] phase_o,
  output logic [ACC_W-1:0] mod_o,
  output logic             wrap_o
);
  logic [ACC_W-1:0] step_q, mod_q, phase_q;
  logic             wrap_q;

  // named internal events
  logic [ACC_W:0]   sum_w;
  logic             wrap_evt;
  logic             restart_evt;
  logic [ACC_W-1:0] next_w;

  function automatic logic [ACC_W:0] wide_add(input logic [ACC_W-1:0] a,
                                              input logic [ACC_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  always_comb begin
    sum_w       = wide_add(phase_q, step_q);
    restart_evt = clr_i | load_i;
    if (mod_q == '0) begin
      wrap_evt = sum_w[ACC_W];
      next_w   = sum_w[ACC_W-1:0];
    end else begin
      wrap_evt = (sum_w >= {1'b0, mod_q});
      next_w   = wrap_evt ? ACC_W'(sum_w - {1'b0, mod_q}) : sum_w[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q  <= '0;
      mod_q   <= '0;
      phase_q <= '0;
      wrap_q  <= 1'b0;
    end else begin
      if (load_i) begin
        step_q <= step_i;
        mod_q  <= mod_i;
      end
      if (restart_evt) begin
        phase_q <= '0;
        wrap_q  <= 1'b0;
      end else begin
        phase_q <= next_w;
        wrap_q  <= wrap_evt;
      end
    end
  end

  assign phase_o = phase_q;
  assign mod_o   = mod_q;
  assign wrap_o  = wrap_q;

  AST_PHASE_BELOW_MOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_q != '0) |-> (phase_q < mod_q)); // R2
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(step_q) && $stable(mod_q))); // R4
  AST_CLEAR_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i || load_i) |=> (phase_q == '0 && !wrap_q)); // R5
  AST_WRAP_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_q |-> (phase_q < $past(phase_q))); // R6
endmodule

// File: rtl/dds_addr_map.sv
module dds_addr_map #(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ACC_W-1:0]  phase_i,
  input  logic [ACC_W-1:0]  mod_i,
  input  logic              wrap_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wrap_o
);
  localparam int PROD_W = ACC_W + ADDR_W;

  logic [ADDR_W-1:0] addr_d, addr_q;
  logic              wrap_q;

  // phase -> address: top bits in binary mode, scaled to the modulus range otherwise
  function automatic logic [ADDR_W-1:0] phase_to_addr(input logic [ACC_W-1:0] ph,
                                                      input logic [ACC_W-1:0] m);
    logic [PROD_W-1:0] num, den;
    if (m == '0) return ph[ACC_W-1 -: ADDR_W];
    num = {ph, {ADDR_W{1'b0}}};
    den = {{ADDR_W{1'b0}}, m};
    return ADDR_W'(num / den);
  endfunction

  always_comb addr_d = phase_to_addr(phase_i, mod_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      wrap_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      wrap_q <= wrap_i;
    end
  end

  assign addr_o = addr_q;
  assign wrap_o = wrap_q;
endmodule

// File: rtl/dds_sine_quarter.sv
module dds_sine_quarter
  import dds_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int SAMP_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  output logic signed [SAMP_W-1:0] sample_o
);
  localparam int QW    = ADDR_W - 2;
  localparam int AMP_U = 2 ** (SAMP_W - 1) - 1;
  localparam logic [QW:0] QFULL = (QW + 1)'(1) << QW;
  localparam logic signed [SAMP_W-1:0] AMP_S = SAMP_W'(AMP_U);

  quad_e             quad_w;
  logic [QW-1:0]     idx_w;
  logic [QW:0]       fold_w;
  logic              neg_w;
  logic [SAMP_W-2:0] mag_w;
  logic signed [SAMP_W-1:0] sample_d, sample_q;

  // quarter-wave sine in Q15 for u in [0, 2^QW]; 32768 stands for 1.0
  function automatic logic [15:0] quarter_q15(input logic [QW:0] u);
    logic [15:0] xq;
    logic [31:0] x2, t, t2, y;
    xq = 16'(u) << (Q_FRAC - QW);
    x2 = 32'((48'(xq) * 48'(xq)) >> Q_FRAC);
    t  = K_B - 32'((48'(K_C) * 48'(x2)) >> Q_FRAC);
    t2 = K_A - 32'((48'(x2) * 48'(t)) >> Q_FRAC);
    y  = 32'((48'(xq) * 48'(t2)) >> Q_FRAC);
    return (y >= 32'd32767) ? 16'd32768 : 16'(y);
  endfunction

  function automatic logic [SAMP_W-2:0] scale_mag(input logic [15:0] yq);
    logic [47:0] p;
    p = 48'(yq) * 48'(AMP_U);
    return (SAMP_W - 1)'(p >> Q_FRAC);
  endfunction

  always_comb begin
    quad_w = quad_e'(addr_i[ADDR_W-1 -: 2]);
    idx_w  = addr_i[QW-1:0];
    case (quad_w)
      QD_POS_FALL, QD_NEG_FALL: fold_w = QFULL - {1'b0, idx_w};
      default:                  fold_w = {1'b0, idx_w};
    endcase
    neg_w    = (quad_w == QD_NEG_RISE) || (quad_w == QD_NEG_FALL);
    mag_w    = scale_mag(quarter_q15(fold_w));
    sample_d = neg_w ? -$signed({1'b0, mag_w}) : $signed({1'b0, mag_w});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sample_q <= '0;
    else         sample_q <= sample_d;
  end

  assign sample_o = sample_q;

  AST_QUAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[QW-1:0] == '0 && !addr_i[ADDR_W-2]) |=> (sample_q == '0)); // R8
  AST_QUAD_PEAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[QW-1:0] == '0 && addr_i[ADDR_W-2])
      |=> (sample_q == ($past(addr_i[ADDR_W-1]) ? -AMP_S : AMP_S))); // R8
endmodule

// File: rtl/dds_varmod_gen.sv
module dds_varmod_gen #(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 14,
  parameter int SAMP_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [ACC_W-1:0]         step_i,
  input  logic [ACC_W-1:0]         mod_i,
  input  logic                     phase_clr_i,
  output logic [ADDR_W-1:0]        addr_o,
  output logic signed [SAMP_W-1:0] sample_o,
  output logic                     wrap_o
);
  logic [ACC_W-1:0]  phase_w, mod_w;
  logic              acc_wrap_w;
  logic [ADDR_W-1:0] addr_w;

  dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .clr_i   (phase_clr_i),
    .step_i  (step_i),
    .mod_i   (mod_i),
    .phase_o (phase_w),
    .mod_o   (mod_w),
    .wrap_o  (acc_wrap_w)
  );

  dds_addr_map #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_map (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_i (phase_w),
    .mod_i   (mod_w),
    .wrap_i  (acc_wrap_w),
    .addr_o  (addr_w),
    .wrap_o  (wrap_o)
  );

  dds_sine_quarter #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_sine (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_w),
    .sample_o (sample_o)
  );

  assign addr_o = addr_w;
endmodule

// File: tb/test_dds_varmod_gen.sv
module test_dds_varmod_gen;
  localparam int CLK_PERIOD = 10;
  localparam int ACC_W  = 32;
  localparam int ADDR_W = 14;
  localparam int SAMP_W = 16;
  localparam int TOL    = 16;
  localparam longint TWO32 = 64'h1_0000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic clr = 1'b0;
  logic [ACC_W-1:0] step = '0;
  logic [ACC_W-1:0] modv = '0;
  logic [ADDR_W-1:0] addr;
  logic signed [SAMP_W-1:0] samp;
  logic wrap;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    int    addr;
    int    samp;
    bit    wrap;
    bit    exact;
    string addr_req;
  } exp_t;
  exp_t sb_q[$];

  // reference model state
  longint m_ph, m_step, m_mod;
  int     m_addr;
  bit     m_wacc;

  dds_varmod_gen #(.ACC_W(ACC_W), .ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) i_dds_varmod_gen (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .step_i(step), .mod_i(modv),
    .phase_clr_i(clr), .addr_o(addr), .sample_o(samp), .wrap_o(wrap)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int ref_sample(input int a);
    real r;
    r = $sin(2.0 * 3.14159265358979 * a / 16384.0) * 32767.0;
    return $rtoi(r >= 0.0 ? r + 0.5 : r - 0.5);
  endfunction

  // driver side of the scoreboard: model the requirements, push expectations
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_step = 0; m_mod = 0; m_addr = 0; m_wacc = 0;
      sb_q.delete();
    end else begin
      exp_t e;
      longint sum;
      e.addr_req = (m_mod == 0) ? "R3" : "R7";
      e.addr  = (m_mod == 0) ? int'(m_ph >> 18) : int'((m_ph * 16384) / m_mod);
      e.samp  = ref_sample(m_addr);
      e.exact = (m_addr % 4096) == 0;
      e.wrap  = m_wacc;
      sb_q.push_back(e);
      m_addr = e.addr;
      if (clr || load) begin
        m_ph = 0; m_wacc = 0;
      end else begin
        sum = m_ph + m_step;
        if (m_mod == 0) begin
          m_wacc = sum >= TWO32;
          m_ph   = sum % TWO32;
        end else begin
          m_wacc = sum >= m_mod;
          m_ph   = m_wacc ? sum - m_mod : sum;
        end
      end
      if (load) begin
        m_step = longint'(step);
        m_mod  = longint'(modv);
      end
    end
  end

  // monitor side: pop and compare away from the active edge
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      int d;
      e = sb_q.pop_front();
      chk(int'(addr) == e.addr, e.addr_req, "addr_o", addr, e.addr);
      chk(wrap == e.wrap, "R6", "wrap_o", wrap, e.wrap);
      d = int'(samp) - e.samp;
      if (e.exact) chk(d == 0, "R8", "sample_o exact", samp, e.samp);
      else         chk(d <= TOL && d >= -TOL, "R8", "sample_o", samp, e.samp);
    end
  end

  task automatic load_cfg(input logic [ACC_W-1:0] s, input logic [ACC_W-1:0] m);
    @(negedge clk);
    step = s; modv = m; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  // address must advance by a fixed delta each clock
  task automatic check_delta(input int delta, input int n, input string req);
    int prev;
    prev = int'(addr);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(((int'(addr) - prev + 16384) % 16384) == delta, req, "addr delta",
          (int'(addr) - prev + 16384) % 16384, delta);
      prev = int'(addr);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    run(3);
    // R1: reset state
    chk(addr == '0, "R1", "addr_o in reset", addr, 0);
    chk(samp == '0, "R1", "sample_o in reset", samp, 0);
    chk(wrap == 1'b0, "R1", "wrap_o in reset", wrap, 0);
    rst_n = 1'b1;
    run(2);

    // R2: slow and fast modulus wraps
    load_cfg(32'd7, 32'd1000);
    run(1050);
    load_cfg(32'd12000, 32'd12345);
    run(300);

    // R3: binary wrap with an irregular step
    load_cfg(32'h9E37_79B9, 32'd0);
    run(200);

    // R9: step multiple of 2^18 keeps the address stride exact
    load_cfg(32'd3 << 18, 32'd0);
    run(3);
    check_delta(3, 40, "R9");

    // R4: inputs change without load: no effect at the outputs
    step = 32'd5;
    modv = 32'd77;
    check_delta(3, 60, "R4");

    // R5: clear restarts the phase
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    @(negedge clk);
    chk(addr == '0, "R5", "addr_o after clear", addr, 0);
    run(20);

    // R8: quadrant points, then a full sweep of the table
    load_cfg(32'd1 << 30, 32'd0);
    run(20);
    load_cfg(32'd1, 32'd16384);
    run(16400);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule